// File: doc/BRIEF.md
# Shift Unit with Status Flags

This block is the shift slice of a small integer execution stage. It takes one data operand, picks a shift distance from either a 5-bit immediate field or a register value, and shifts right arithmetically, right logically, or left logically. In the same pass it works out the four status bits that a shift instruction hands to the program status word: zero, sign, carry and overflow.

Everything is combinational, so the result and flags appear in the same cycle as the operands. A write mask tells the status-word logic which of its bits to update. The mask is raised only when the input is qualified as valid and the operation code is a legal one. The register file, the instruction decoder and the status-word register are outside this block.

Top module: `shift_flag_unit`

## Requirements
- R1: The shift distance is `immAmt` zero-extended when `amtFromReg` is 0. It is the low 5 bits of `regAmt` when `amtFromReg` is 1, and the upper bits of `regAmt` are ignored.
- R2: With `opSel` = 0, the result is an arithmetic right shift, and vacated high bits copy operand bit 31.
- R3: With `opSel` = 1, the result is a logical right shift, and vacated high bits are 0.
- R4: With `opSel` = 2, the result is a logical left shift, and vacated low bits are 0.
- R5: `flagZero` is 1 exactly when the 32-bit result is zero.
- R6: `flagSign` equals bit 31 of the result.
- R7: For a right shift by n ≥ 1, `flagCarry` equals operand bit n-1.
- R8: For a left shift by n ≥ 1, `flagCarry` equals operand bit 32-n.
- R9: A shift distance of 0 returns the operand unchanged and gives `flagCarry` = 0.
- R10: `flagOverflow` is always 0.
- R11: `flagWriteMask` is 4'b1111 when `inValid` is 1 and `opSel` is 0, 1 or 2. Otherwise it is 4'b0000. The bit order is [0] zero, [1] sign, [2] carry, [3] overflow.
- R12: `opSel` = 3 is reserved. The result equals the operand, `flagCarry` is 0, and zero and sign follow the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inValid | input | 1 | Qualifies the operation for the flag write mask |
| opSel | input | 2 | 0 arithmetic right, 1 logical right, 2 left, 3 reserved |
| amtFromReg | input | 1 | 1 selects the register distance, 0 selects the immediate |
| immAmt | input | 5 | Immediate shift distance |
| regAmt | input | 32 | Register value supplying the distance (low 5 bits used) |
| operand | input | 32 | Data to be shifted |
| result | output | 32 | Shifted value |
| flagZero | output | 1 | Result is zero |
| flagSign | output | 1 | Result bit 31 |
| flagCarry | output | 1 | Last bit shifted out |
| flagOverflow | output | 1 | Always 0 |
| flagWriteMask | output | 4 | Status bits to update |

## Verification
The block holds no state, so a wrong decode strobe or a wrong shifter stage shows up at the ports in the same cycle as the stimulus. The bench's model is evaluated against every applied input. Each operation is swept over all 32 distances from both amount sources, using random and edge-pattern operands. This sweep reaches each barrel stage both on and off, and it reaches the carry guard bit at every depth. Reserved codes and deasserted valid are mixed in to expose a mask or pass-through fault.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    OP_SAR  = 2'd0,
    OP_SHR  = 2'd1,
    OP_SHL  = 2'd2,
    OP_RSVD = 2'd3
  } shf_op_e;

  typedef struct packed {
    logic reverse;
    logic fillSign;
  } shf_ctrl_t;

  localparam int MASK_BITS = 4;
  localparam int MB_ZERO  = 0;
  localparam int MB_SIGN  = 1;
  localparam int MB_CARRY = 2;
  localparam int MB_OVF   = 3;
endpackage

// File: rtl/shf_control.sv
module shf_control
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic                 inValid,
  input  logic [1:0]           opSel,
  input  logic                 amtFromReg,
  input  logic [AMT_W-1:0]     immAmt,
  input  logic [WIDTH-1:0]     regAmt,
  output shf_ctrl_t            ctl,
  output logic [AMT_W-1:0]     amt,
  output logic [MASK_BITS-1:0] writeMask
);
  logic legalOp;

  always_comb begin
    legalOp      = (opSel != OP_RSVD);
    ctl.reverse  = (opSel == OP_SHL);
    ctl.fillSign = (opSel == OP_SAR);
    if (!legalOp)
      amt = '0;                                  // reserved: pass through
    else if (amtFromReg)
      amt = regAmt[AMT_W-1:0];                   // R1 low bits only
    else
      amt = immAmt;
    writeMask = (inValid && legalOp) ? {MASK_BITS{1'b1}} : '0;
  end

  always_comb begin
    if (!(inValid && legalOp))
      AST_MASK_IDLE: assert (writeMask == '0); // R11
  end
endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] dIn,
  input  shf_ctrl_t        ctl,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] dOut,
  output logic             zeroOut,
  output logic             signOut,
  output logic             carryOut
);
  logic [WIDTH-1:0] revIn;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] revOut;
  logic [WIDTH:0]   stg [0:AMT_W];
  logic             fillBit;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_rev
      assign revIn[gi]  = dIn[WIDTH-1-gi];
      assign revOut[gi] = shifted[WIDTH-1-gi];
    end
  endgenerate

  assign fillBit = ctl.fillSign & dIn[WIDTH-1];
  // Guard bit below the LSB collects the last bit shifted out.
  assign stg[0] = {(ctl.reverse ? revIn : dIn), 1'b0};

  generate
    for (gi = 0; gi < AMT_W; gi++) begin : g_stage
      localparam int SH = 2 ** gi;
      assign stg[gi+1] = amt[gi] ? {{SH{fillBit}}, stg[gi][WIDTH:SH]} : stg[gi];
    end
  endgenerate

  assign shifted  = stg[AMT_W][WIDTH:1];
  assign carryOut = stg[AMT_W][0];
  assign dOut     = ctl.reverse ? revOut : shifted;
  assign zeroOut  = (dOut == '0);
  assign signOut  = dOut[WIDTH-1];

  always_comb begin
    if (amt == '0) begin
      AST_ZERO_AMT_PASS: assert (dOut == dIn && !carryOut); // R9
    end
  end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic                 inValid,
  input  logic [1:0]           opSel,
  input  logic                 amtFromReg,
  input  logic [AMT_W-1:0]     immAmt,
  input  logic [WIDTH-1:0]     regAmt,
  input  logic [WIDTH-1:0]     operand,
  output logic [WIDTH-1:0]     result,
  output logic                 flagZero,
  output logic                 flagSign,
  output logic                 flagCarry,
  output logic                 flagOverflow,
  output logic [MASK_BITS-1:0] flagWriteMask
);
  shf_ctrl_t        ctl;
  logic [AMT_W-1:0] amt;

  shf_control #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_ctrl (
    .inValid   (inValid),
    .opSel     (opSel),
    .amtFromReg(amtFromReg),
    .immAmt    (immAmt),
    .regAmt    (regAmt),
    .ctl       (ctl),
    .amt       (amt),
    .writeMask (flagWriteMask)
  );

  shf_datapath #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dp (
    .dIn     (operand),
    .ctl     (ctl),
    .amt     (amt),
    .dOut    (result),
    .zeroOut (flagZero),
    .signOut (flagSign),
    .carryOut(flagCarry)
  );

  assign flagOverflow = 1'b0; // R10

  always_comb begin
    if (opSel == OP_SAR && amt != '0)
      AST_ARITH_MSB: assert (result[WIDTH-1] == operand[WIDTH-1]); // R2
    if (opSel == OP_SHR && amt != '0)
      AST_LOGIC_MSB: assert (result[WIDTH-1] == 1'b0); // R3
    if (opSel == OP_SHL && amt != '0)
      AST_LEFT_LSB: assert (result[0] == 1'b0); // R4
  end
endmodule

// File: tb/shift_flag_unit_test.sv
module shift_flag_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        inValid;
  logic [1:0]  opSel;
  logic        amtFromReg;
  logic [4:0]  immAmt;
  logic [31:0] regAmt;
  logic [31:0] operand;
  logic [31:0] result;
  logic        flagZero, flagSign, flagCarry, flagOverflow;
  logic [3:0]  flagWriteMask;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_flag_unit uut (
    .inValid(inValid), .opSel(opSel), .amtFromReg(amtFromReg),
    .immAmt(immAmt), .regAmt(regAmt), .operand(operand),
    .result(result), .flagZero(flagZero), .flagSign(flagSign),
    .flagCarry(flagCarry), .flagOverflow(flagOverflow),
    .flagWriteMask(flagWriteMask)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (op=%0d src=%0d imm=%0d reg=%h opnd=%h)",
               req, act, exp, opSel, amtFromReg, immAmt, regAmt, operand);
    end
  endtask

  task automatic apply(input bit v, input int op, input bit src, input logic [4:0] imm,
                       input logic [31:0] ra, input logic [31:0] d);
    int n;
    logic [31:0] eRes;
    logic        eCy;
    @(posedge clk);
    inValid = v; opSel = op[1:0]; amtFromReg = src;
    immAmt = imm; regAmt = ra; operand = d;
    n = src ? (ra % 32) : int'(imm);             // R1
    eRes = d; eCy = 1'b0;
    if (op == 0) begin                           // R2
      for (int k = 0; k < n; k++) begin eCy = eRes[0]; eRes = {eRes[31], eRes[31:1]}; end
    end else if (op == 1) begin                  // R3
      for (int k = 0; k < n; k++) begin eCy = eRes[0]; eRes = {1'b0, eRes[31:1]}; end
    end else if (op == 2) begin                  // R4
      for (int k = 0; k < n; k++) begin eCy = eRes[31]; eRes = {eRes[30:0], 1'b0}; end
    end
    @(negedge clk);
    check(op == 3 ? "R12 result" : (n == 0 ? "R9 result" : "R1/R2/R3/R4 result"), result, eRes);
    check("R5 zero", {31'b0, flagZero}, {31'b0, eRes == 32'b0});
    check("R6 sign", {31'b0, flagSign}, {31'b0, eRes[31]});
    check(op == 2 ? "R8 carry" : "R7/R9 carry", {31'b0, flagCarry}, {31'b0, eCy});
    check("R10 overflow", {31'b0, flagOverflow}, 32'b0);
    check("R11 mask", {28'b0, flagWriteMask}, (v && op != 3) ? 32'hF : 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    inValid = 0; opSel = 0; amtFromReg = 0; immAmt = 0; regAmt = 0; operand = 0;
    // idle state: zero operand, nothing valid
    apply(0, 0, 0, 5'd0, 32'd0, 32'd0);
    // edge patterns
    apply(1, 0, 0, 5'd31, 32'd0, 32'h8000_0000);  // R2 all ones
    apply(1, 1, 0, 5'd31, 32'd0, 32'h8000_0000);  // R3 -> 1
    apply(1, 2, 0, 5'd31, 32'd0, 32'h0000_0001);  // R4 -> msb, R8 carry bit 1
    apply(1, 2, 0, 5'd1,  32'd0, 32'h8000_0000);  // R8 carry from bit 31, zero result
    apply(1, 1, 1, 5'd0,  32'hFFFF_FFE4, 32'h0000_0010); // R1 upper regAmt bits ignored
    apply(1, 3, 1, 5'd7,  32'd9, 32'hDEAD_BEEF);  // R12 reserved
    apply(1, 0, 0, 5'd0,  32'd0, 32'hFFFF_FFFF);  // R9 zero distance
    // sweep every op, distance and source
    for (int op = 0; op < 4; op++)
      for (int n = 0; n < 32; n++)
        for (int s = 0; s < 2; s++)
          for (int r = 0; r < 4; r++) begin
            logic [31:0] d, ra;
            d  = (r == 0) ? 32'hFFFF_FFFF : $urandom;
            ra = {$urandom} & 32'hFFFF_FFE0 | 32'(n);
            apply(r != 3, op, s[0], s[0] ? 5'($urandom) : 5'(n), ra, d);
          end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule